// File: doc/BRIEF.md
# Two-Channel Masked Interrupt Combiner

This block merges the interrupt requests of two disk channels into one shared interrupt line. Each channel drives a level input. The block samples that level into a per-channel pending flag, and software can block each channel with its own mask flag. The shared line is high while at least one channel is pending and not blocked.

Software reaches the block through a byte-wide register port with a two-bit address. The mode register reads back the pending and block flags together. A write to it changes only the block flags. Each channel also has an 8-bit timing register, which is plain storage that reads back the last value written. Bus decoding and the channels themselves are outside this block. The register port is a plain control interface with no handshake: a write takes effect at the next clock edge, and a read returns data combinationally from the current state.

Top module: `irq_merge`

## Requirements
- R1: Mode register (address 0) bit 2 shows channel 0 pending and bit 3 shows channel 1 pending. Bits 0, 1, 6 and 7 always read as 0.
- R2: Mode register bit 4 is the channel 0 block flag and bit 5 is the channel 1 block flag. Both can be written and read back.
- R3: `irq_out` equals (pending0 AND NOT block0) OR (pending1 AND NOT block1), taken from the state after the previous edge. It is a flop output.
- R4: A high level on `chan_lvl[i]` at a clock edge sets pending bit i. A low level at a clock edge clears it.
- R5: A write to the mode register changes only bits 4 and 5. The written values of bits 2 and 3 have no effect on the pending flags.
- R6: Address 1 holds the channel 0 timing byte and address 2 holds the channel 1 timing byte. Each reads back the last value written to it and is unaffected by writes to the other.
- R7: Reset (`rst_n` low) clears both pending flags, both block flags and both timing bytes, and drives `irq_out` low.
- R8: Address 3 reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_lvl | input | 2 | Interrupt level of each channel |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address: 0 mode, 1 timing ch0, 2 timing ch1, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt line |

## Verification
A level change on a channel input, or a write to the block flags, is latched at the first edge. The output follows at the second edge. For every driven cycle the bench therefore queues an expected output value that is due two edges later. A monitor compares that value at the falling edge of the cycle in which it is due. Register reads are combinational from state latched at the previous edge, so they are compared within the same cycle. The bench samples them just after it drives the address.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int NCH      = 2;
  localparam int DW       = 8;
  localparam int PEND_LSB = 2;
  localparam int MASK_LSB = 4;

  typedef enum logic [1:0] {
    RA_MODE = 2'd0,
    RA_TIM0 = 2'd1,
    RA_TIM1 = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_merge_mode.sv
// Pending flags track the channel levels; block flags are software storage.
module irq_merge_mode #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lvl,
  input  logic           wr_mask,
  input  logic [NCH-1:0] wmask,
  output logic [NCH-1:0] pend_q,
  output logic [NCH-1:0] mask_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        pend_q[i] <= lvl[i];
        if (wr_mask) mask_q[i] <= wmask[i];
      end
    end
  end
endmodule

// File: rtl/irq_merge_timing.sv
// One storage byte per channel.
module irq_merge_timing #(
  parameter int NCH = 2,
  parameter int DW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          wr_en,
  input  logic [DW-1:0]           wdata,
  output logic [NCH-1:0][DW-1:0]  tim_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_tim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tim_q[i] <= '0;
      else if (wr_en[i]) tim_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/irq_merge_out.sv
// Registered OR of unblocked pending terms.
module irq_merge_out #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] mask,
  output logic           irq_q
);
  logic [NCH-1:0] live;

  always_comb live = pend & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_merge_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    chan_lvl,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_out
);
  localparam int MASK_MSB = MASK_LSB + NCH - 1;

  logic [NCH-1:0]         pend_q;
  logic [NCH-1:0]         mask_q;
  logic [NCH-1:0][DW-1:0] tim_q;
  logic                   wr_mode;
  logic [NCH-1:0]         wr_tim;
  logic [DW-1:0]          mode_byte;

  always_comb begin
    wr_mode = reg_wr && (reg_addr == RA_MODE);
    for (int i = 0; i < NCH; i++)
      wr_tim[i] = reg_wr && (reg_addr == 2'(i + 1));
  end

  irq_merge_mode #(.NCH(NCH)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (chan_lvl),
    .wr_mask (wr_mode),
    .wmask   (reg_wdata[MASK_MSB:MASK_LSB]),
    .pend_q  (pend_q),
    .mask_q  (mask_q)
  );

  irq_merge_timing #(.NCH(NCH), .DW(DW)) u_tim (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_tim),
    .wdata (reg_wdata),
    .tim_q (tim_q)
  );

  irq_merge_out #(.NCH(NCH)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_q),
    .mask  (mask_q),
    .irq_q (irq_out)
  );

  always_comb begin
    mode_byte = '0;
    mode_byte[PEND_LSB +: NCH] = pend_q;
    mode_byte[MASK_LSB +: NCH] = mask_q;
  end

  always_comb begin
    case (reg_addr)
      RA_MODE: reg_rdata = mode_byte;
      RA_TIM0: reg_rdata = tim_q[0];
      RA_TIM1: reg_rdata = tim_q[1];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       chan_lvl,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             irq_out,
  input logic [1:0]       pend,
  input logic [1:0]       mask,
  input logic [1:0][7:0]  tim
);
  p_pend_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend == $past(chan_lvl));

  p_out_terms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == $past(|(pend & ~mask)));

  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> mask == $past(reg_wdata[5:4]));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd0) |=> $stable(mask));

  p_tim_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == 2'd1 || reg_addr == 2'd2)) |=> $stable(tim));

  // R7: state is clear while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r7: assert (!irq_out && pend == '0 && mask == '0 && tim == '0);
    end
  end
endmodule

bind irq_merge irq_merge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_lvl  (chan_lvl),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_out   (irq_out),
  .pend      (pend_q),
  .mask      (mask_q),
  .tim       (tim_q)
);

// File: tb/irq_merge_tb.sv
module irq_merge_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_lvl = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int   due;
    logic val;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_mask = '0;
  logic [1:0] m_lvl  = '0;
  logic [7:0] m_tim0 = '0;
  logic [7:0] m_tim1 = '0;

  irq_merge u_dut (
    .clk(clk), .rst_n(rst_n), .chan_lvl(chan_lvl), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // R3 scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (irq_out !== e.val) begin
          bad++;
          $display("FAIL R3 irq_out cyc=%0d actual=%0b expected=%0b", cyc, irq_out, e.val);
        end
      end
    end
  end

  // one driven cycle; called at a negedge
  task automatic step(input logic [1:0] lvl, input logic wr,
                      input logic [1:0] addr, input logic [7:0] d);
    chan_lvl = lvl; reg_wr = wr; reg_addr = addr; reg_wdata = d;
    m_lvl = lvl;
    if (wr) begin
      case (addr)
        2'd0: m_mask = d[5:4];
        2'd1: m_tim0 = d;
        2'd2: m_tim1 = d;
        default: ;
      endcase
    end
    q.push_back('{due: cyc + 2, val: |(lvl & ~m_mask)});
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] addr, input logic [7:0] exp, input string tag);
    reg_wr = 1'b0; reg_addr = addr;
    #1;
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, addr, reg_rdata, exp);
    end
    step(m_lvl, 1'b0, addr, 8'h00);
  endtask

  function automatic logic [7:0] mode_exp();
    return {2'b00, m_mask, m_lvl, 2'b00};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    chan_lvl = 2'b11;
    repeat (3) @(negedge clk);
    // R7: reset state even with levels high
    total++;
    if (irq_out !== 1'b0) begin bad++; $display("FAIL R7 irq actual=%0b expected=0", irq_out); end
    reg_addr = 2'd0; #1;
    total++;
    if (reg_rdata !== 8'h00) begin bad++; $display("FAIL R7 mode actual=%02h expected=00", reg_rdata); end
    chan_lvl = 2'b00;
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd1, 8'h00, "R7 tim0");
    rd(2'd2, 8'h00, "R7 tim1");

    // R4/R1/R3: channel levels set and clear pending
    step(2'b01, 0, 2'd3, 0);
    rd(2'd0, mode_exp(), "R1 R4 ch0 pending");
    step(2'b10, 0, 2'd3, 0);
    rd(2'd0, mode_exp(), "R1 R4 ch1 pending");
    step(2'b00, 0, 2'd3, 0);
    rd(2'd0, mode_exp(), "R4 pending cleared");

    // R2/R5: write 0xFF with levels low: only mask bits change
    step(2'b00, 1, 2'd0, 8'hFF);
    rd(2'd0, 8'h30, "R5 R2 mask only");
    step(2'b11, 0, 2'd3, 0);           // R3: both blocked, output low
    rd(2'd0, 8'h3C, "R1 R2 both");
    step(2'b11, 1, 2'd0, 8'h10);       // unblock ch1
    rd(2'd0, 8'h1C, "R2 block ch0 only");
    step(2'b01, 0, 2'd3, 0);           // ch0 blocked, pending -> low
    step(2'b10, 0, 2'd3, 0);           // ch1 unblocked -> high
    step(2'b11, 1, 2'd0, 8'h20);       // swap blocks
    step(2'b01, 0, 2'd3, 0);
    step(2'b01, 1, 2'd0, 8'h0C);       // R5: pending bits in data ignored
    rd(2'd0, 8'h04, "R5 pending not writable");
    step(2'b00, 0, 2'd3, 0);
    rd(2'd0, 8'h00, "R5 written pending ignored");

    // R6 timing storage
    step(2'b00, 1, 2'd1, 8'hA5);
    step(2'b00, 1, 2'd2, 8'h3C);
    rd(2'd1, 8'hA5, "R6 tim0");
    rd(2'd2, 8'h3C, "R6 tim1");
    step(2'b00, 1, 2'd1, 8'h5A);
    rd(2'd1, 8'h5A, "R6 tim0 rewrite");
    rd(2'd2, 8'h3C, "R6 tim1 untouched");

    // R8 unused address
    step(2'b01, 1, 2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R8 unused read");
    rd(2'd0, mode_exp(), "R8 mode untouched");
    rd(2'd1, 8'h5A, "R8 tim0 untouched");
    rd(2'd2, 8'h3C, "R8 tim1 untouched");

    // R3 toggling pattern, all masks clear
    step(2'b00, 1, 2'd0, 8'h00);
    for (int k = 0; k < 16; k++) step(2'(k ^ (k >> 1)), 0, 2'd3, 0);
    step(2'b00, 0, 2'd3, 0);
    step(2'b00, 0, 2'd3, 0);
    step(2'b00, 0, 2'd3, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule